// File: doc/BRIEF.md
# Prioritised Eight-Line Interrupt Controller

This block gathers interrupt requests from eight device lines and presents a single interrupt signal to a processor. Each request is captured in a pending register and stays there until the processor takes it. A per-line mask decides whether a pending line may be forwarded. Among the forwardable lines, a fixed priority picks one: line 0 outranks line 7. Any line that is still being serviced holds back itself and every line below it.

When a line is chosen, the controller raises `intr` and then freezes. It forwards nothing else until the processor pulses `ack`, and its choice does not change while it waits. On `ack` the chosen line leaves the pending register and enters the in-service register. One cycle later the controller presents an 8-bit vector for one cycle. The vector is made of a programmable 5-bit base in its upper bits and the line number in its lower 3 bits. Software ends service of a line by writing an end-of-service word, which clears in-service bits.

A small write port sets the mask and the vector base and carries the end-of-service word.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `intr` and `vec_valid` are low, `vector` is 0, the vector base is 0, all eight lines are masked, and no line is pending or in service.
- R2: A high level on `irq_in[i]` sets pending bit i, whether or not line i is masked. The bit stays set after the input drops, until that line is acknowledged.
- R3: A masked line (mask bit i = 1) never causes `intr`. A line that became pending while masked is delivered once its mask bit is cleared.
- R4: Among unmasked pending lines that are not blocked, the lowest-numbered line is granted.
- R5: While line k is in service, lines k..7 are held back. A pending line numbered below k is still delivered.
- R6: Once `intr` rises, it stays high and the granted line stays fixed until `ack`. Requests that arrive meanwhile do not change the grant.
- R7: `ack` with `intr` high has these effects in the next cycle: `intr` is low, `vec_valid` is high for exactly one cycle, and `vector` = {base[4:0], line[2:0]}. The granted line's pending bit is clear and its in-service bit is set.
- R8: A write to address 2 clears in-service bit i for every set bit i of `wr_data`.
- R9: `ack` while `intr` is low has no effect: `vec_valid` stays low and no state changes.
- R10: A write to address 0 loads the mask from `wr_data` (bit i = 1 masks line i). A write to address 1 loads the base from `wr_data[7:3]`. A write to address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Level request lines from devices |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 mask, 1 base, 2 end of service, 3 none |
| wr_data | input | 8 | Write data |
| ack | input | 1 | Acknowledge pulse from the processor |
| intr | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the last acknowledged line |
| vec_valid | output | 1 | One-cycle strobe marking a fresh vector |

## Verification
The bench sweeps every request pattern with all lines unmasked and drains each one. This checks that lines come out in ascending order with the right vector. A resolver that chose by the wrong end, or an in-service check that let a lower line through, would break that order. The bench also sweeps every mask value against all eight lines requesting, and then unmasks. A design that dropped masked requests would lose them here, and one that ignored the mask would raise `intr` too early. Separate cases raise a higher-priority request while `intr` waits, and nest a higher line over a line still in service. A controller that re-arbitrated before `ack`, or that released a blocked line before its end-of-service write, would deliver the wrong vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES  = 8;
  localparam int ID_W   = $clog2(LINES);
  localparam int VEC_W  = 8;
  localparam int BASE_W = VEC_W - ID_W;

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [ID_W-1:0]  line_id_t;

  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_EOS  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } hs_state_e;

  // lowest-numbered set bit (highest priority); 0 when empty
  function automatic line_id_t first_set(line_vec_t v);
    line_id_t r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = line_id_t'(i);
    return r;
  endfunction

  // every line at or below the priority of the best in-service line
  function automatic line_vec_t blocked_by(line_vec_t isr);
    line_vec_t b;
    logic seen;
    b = '0;
    seen = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      seen = seen | isr[i];
      b[i] = seen;
    end
    return b;
  endfunction

  function automatic logic [VEC_W-1:0] make_vector(logic [BASE_W-1:0] base, line_id_t id);
    return {base, id};
  endfunction

  function automatic line_vec_t id_to_bit(line_id_t id);
    return line_vec_t'(1) << id;
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [VEC_W-1:0]  wr_data,
  output line_vec_t         mask_q,
  output logic [BASE_W-1:0] base_q,
  output line_vec_t         eos_clr
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      base_q <= '0;
    end else if (wr_en) begin
      if (sel == REG_MASK) mask_q <= line_vec_t'(wr_data);
      if (sel == REG_BASE) base_q <= wr_data[VEC_W-1:ID_W];
    end
  end

  assign eos_clr = (wr_en && sel == REG_EOS) ? line_vec_t'(wr_data) : '0;
endmodule

// File: rtl/irqc_lines.sv
module irqc_lines
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  line_vec_t ack_set,
  input  line_vec_t eos_clr,
  output line_vec_t req_q,
  output line_vec_t isr_q
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_q[i] <= 1'b0;
        isr_q[i] <= 1'b0;
      end else begin
        req_q[i] <= (req_q[i] | irq_in[i]) & ~ack_set[i];
        isr_q[i] <= (isr_q[i] & ~eos_clr[i]) | ack_set[i];
      end
    end
  end
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve
  import irqc_pkg::*;
(
  input  line_vec_t req_q,
  input  line_vec_t mask_q,
  input  line_vec_t isr_q,
  output line_vec_t cand,
  output logic      cand_any,
  output line_id_t  cand_id
);
  assign cand     = req_q & ~mask_q & ~blocked_by(isr_q);
  assign cand_any = |cand;
  assign cand_id  = first_set(cand);
endmodule

// File: rtl/irqc_handshake.sv
module irqc_handshake
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_any,
  input  line_id_t          cand_id,
  input  logic              ack,
  input  logic [BASE_W-1:0] base_q,
  output logic              intr,
  output line_id_t          grant_id,
  output logic              raise,
  output logic              take,
  output logic [VEC_W-1:0]  vector,
  output logic              vec_valid
);
  hs_state_e state_q;

  assign raise = (state_q == ST_IDLE) && cand_any;
  assign take  = (state_q == ST_WAIT) && ack;
  assign intr  = (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      grant_id  <= '0;
      vector    <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= take;
      if (raise) begin
        state_q  <= ST_WAIT;
        grant_id <= cand_id;
      end else if (take) begin
        state_q <= ST_IDLE;
        vector  <= make_vector(base_q, grant_id);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       irq_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             ack,
  output logic             intr,
  output logic [7:0]       vector,
  output logic             vec_valid
);
  line_vec_t         mask_q, req_q, isr_q, eos_clr, ack_set, cand;
  logic [BASE_W-1:0] base_q;
  logic              cand_any, raise, take;
  line_id_t          cand_id, grant_id;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mask_q(mask_q), .base_q(base_q), .eos_clr(eos_clr)
  );

  assign ack_set = take ? id_to_bit(grant_id) : '0;

  irqc_lines u_lines (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_set(ack_set),
    .eos_clr(eos_clr), .req_q(req_q), .isr_q(isr_q)
  );

  irqc_resolve u_resolve (
    .req_q(req_q), .mask_q(mask_q), .isr_q(isr_q),
    .cand(cand), .cand_any(cand_any), .cand_id(cand_id)
  );

  irqc_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .cand_any(cand_any), .cand_id(cand_id),
    .ack(ack), .base_q(base_q), .intr(intr), .grant_id(grant_id),
    .raise(raise), .take(take), .vector(vector), .vec_valid(vec_valid)
  );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       intr,
  input logic       ack,
  input logic       vec_valid,
  input logic [7:0] vector,
  input line_id_t   grant_id,
  input line_id_t   cand_id,
  input line_vec_t  isr_q,
  input line_vec_t  mask_q,
  input logic       raise,
  input logic       take
);
  assert_intr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !ack |=> intr);
  assert_grant_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    intr && !ack |=> $stable(grant_id));
  assert_vec_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> vec_valid && !intr);
  assert_vec_needs_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(take));
  assert_vec_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vector[ID_W-1:0] == $past(grant_id));
  assert_isr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> isr_q[vector[ID_W-1:0]]);
  assert_raise_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    raise |-> !mask_q[cand_id]);
  assert_raise_above_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raise && (isr_q != '0) |-> cand_id < first_set(isr_q));
  assert_idle_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !intr |=> !vec_valid);
endmodule

bind irq_prio_ctrl irqc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .intr(intr), .ack(ack), .vec_valid(vec_valid),
  .vector(vector), .grant_id(grant_id), .cand_id(cand_id), .isr_q(isr_q),
  .mask_q(mask_q), .raise(raise), .take(take)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic       intr, vec_valid;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack), .intr(intr),
    .vector(vector), .vec_valid(vec_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_irq(input logic [7:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic wait_intr(input string req);
    int n = 0;
    while (!intr && n < 8) begin
      @(negedge clk);
      n++;
    end
    chk(req, intr, 1'b1);
  endtask

  task automatic do_ack(input string req, input int id, input logic [4:0] base);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk({req, " vec_valid"}, vec_valid, 1'b1);
    chk({req, " vector"}, vector, {base, 3'(id)});
    chk({req, " intr drop"}, intr, 1'b0);
  endtask

  task automatic expect_none(input string req, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (intr) seen = 1;
    end
    chk(req, seen, 1'b0);
  endtask

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // service every line of rem in priority order
  task automatic drain(input string req, input logic [7:0] rem_in, input logic [4:0] base);
    logic [7:0] rem = rem_in;
    while (rem != 0) begin
      int id = lowest(rem);
      wait_intr(req);
      do_ack(req, id, base);
      wr(2'd2, 8'(1 << id));
      rem[id] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 intr", intr, 1'b0);
    chk("R1 vec_valid", vec_valid, 1'b0);
    chk("R1 vector", vector, 8'h00);
    rst_n = 1'b1;
    // R1/R2: lines masked after reset, request held while masked
    pulse_irq(8'h01);
    expect_none("R1 masked after reset", 5);
    wr(2'd0, 8'h00);
    wait_intr("R2 held request delivered");
    do_ack("R2 base zero", 0, 5'd0);
    @(negedge clk);
    chk("R7 vec_valid one cycle", vec_valid, 1'b0);
    wr(2'd2, 8'h01);

    // R9: ack while idle
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R9 idle ack vec_valid", vec_valid, 1'b0);
    chk("R9 idle ack intr", intr, 1'b0);

    // R4/R7/R8: every request pattern, unmasked, varying base
    for (int p = 1; p < 256; p++) begin
      logic [4:0] b = 5'(p * 7);
      wr(2'd1, {b, 3'b101});
      pulse_irq(8'(p));
      drain("R4 priority sweep", 8'(p), b);
    end
    expect_none("R8 all serviced", 4);

    // R3: every mask against all lines, then unmask
    wr(2'd1, 8'h00);
    for (int m = 0; m < 256; m++) begin
      wr(2'd0, 8'(m));
      pulse_irq(8'hFF);
      drain("R3 unmasked lines", ~8'(m), 5'd0);
      expect_none("R3 masked lines silent", 3);
      wr(2'd0, 8'h00);
      drain("R3 delivered after unmask", 8'(m), 5'd0);
    end

    // R6: grant frozen while waiting for ack
    wr(2'd1, 8'hA8);
    pulse_irq(8'h10);
    wait_intr("R6 raise line4");
    pulse_irq(8'h02);
    repeat (3) @(negedge clk);
    chk("R6 intr held", intr, 1'b1);
    do_ack("R6 grant kept", 4, 5'h15);
    wr(2'd2, 8'h10);
    drain("R6 later line1", 8'h02, 5'h15);

    // R5: nesting over an in-service line
    pulse_irq(8'h20);
    wait_intr("R5 raise line5");
    do_ack("R5 line5", 5, 5'h15);
    pulse_irq(8'h40);
    expect_none("R5 line6 blocked", 5);
    pulse_irq(8'h04);
    wait_intr("R5 line2 preempts");
    do_ack("R5 line2", 2, 5'h15);
    wr(2'd2, 8'h04);
    expect_none("R5 line6 still blocked by 5", 5);
    pulse_irq(8'h20);
    expect_none("R5 line5 blocks itself", 4);
    wr(2'd2, 8'h20);
    drain("R5 after eos", 8'h60, 5'h15);

    // R10: address 3 ignored, mask bit semantics
    wr(2'd3, 8'hFF);
    pulse_irq(8'h08);
    wait_intr("R10 addr3 no mask");
    do_ack("R10 base unchanged", 3, 5'h15);
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h08);
    pulse_irq(8'h08);
    expect_none("R10 mask bit3", 4);
    wr(2'd0, 8'h00);
    drain("R10 unmask bit3", 8'h08, 5'h15);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule